// File: doc/BRIEF.md
# Field-Masked RAM Card Controller

This block steers a static RAM card that fills a 32K-word, 12-bit memory space on a minicomputer backplane. A 3-bit field number extends the 12-bit word address into eight fields of 4K words each. An eight-bit switch bank removes any field from the card's responsibility, so the card covers only the fields that other memory boards leave empty. A low level on the ROM-overlay input hands the access to ROM. The card puts read data on the shared data bus only while the processor's direction line says it is listening. The power-good input gates the RAM chip enable with no clock in the path, so a failing supply cannot corrupt the stored words.

Card select is registered on the system clock from three inputs: ROM overlay inactive, the field's switch clear, and power good. Reads need no clock. The RAM output follows the address while the card is selected and listening. Writes come from a four-state machine. WR_OFF is the reset state and the state while power is bad. WR_IDLE waits for a strobe. WR_PULSE holds write enable low for exactly one cycle. WR_HOLD waits for the strobe to be released.

The transitions are these. Any state goes to WR_OFF while power is bad. WR_OFF goes to WR_HOLD if the strobe is high and to WR_IDLE if it is low. WR_IDLE goes to WR_PULSE on a strobe that arrives while the card is selected with the processor driving. It goes to WR_HOLD on a strobe under any other conditions. WR_PULSE and WR_HOLD both go to WR_HOLD while the strobe stays high and to WR_IDLE once it drops.

The included array model is 16 bits wide. It keeps the field number and folds the word address into ROW_BITS (default 6) bits: address bit i is XORed into row bit i mod ROW_BITS. Word addresses in one field that fold to the same row share storage.

Top module: `ramcard_ctrl`

## Requirements
- R1: After reset, chip enable, write enable and output enable are all high, transceiver direction is 0 (bus into RAM) and read data is 0.
- R2: A set switch bit i (bit 0 for field 0 up to bit 7 for field 7) keeps chip enable high for field i, blocks both reads (read data 0) and writes, and leaves the other fields working.
- R3: While the ROM-overlay input is low, chip enable stays high and both reads and writes are blocked, whatever the switches and field.
- R4: The card drives the bus (direction 1, output enable low, read data valid) only when selected with the direction input low. With the direction input high, direction is 0 and read data is 0, while transceiver enable stays low as long as the card is selected.
- R5: When power-good falls, chip enable and write enable go high at once, with no clock edge. No write happens while power is bad, and stored data survives the outage.
- R6: A write strobe that rises while the card is selected, power is good and the direction input is high pulls write enable low on the next clock edge. The value on the write-data input is stored at the current field and address.
- R7: Reads are asynchronous: changing the word address within a selected field changes read data in the same time step, with no clock edge.
- R8: Array words are 16 bits with the upper four written as zero. Only the low 12 bits reach the bus, so a stored 12-bit value returns unchanged.
- R9: A strobe held high for several cycles produces exactly one write-enable pulse of one cycle.
- R10: Select is registered. A change of field, or the return of power-good, takes effect on chip enable only after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_sel | input | 3 | Field number, upper part of the address |
| word_addr | input | 12 | Word address within the field |
| rom_over_n | input | 1 | Active-low ROM overlay; low blocks the card |
| dir_n | input | 1 | Low: processor listens, card may drive the bus |
| pwr_good | input | 1 | High while the supply is valid |
| wr_stb | input | 1 | Write strobe, synchronous to clk |
| fld_mask | input | 8 | Per-field disable switches, bit i for field i |
| mem_wdata | input | 12 | Data from the bus for writes |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| xcvr_dir | output | 1 | Transceiver direction: 1 card to bus, 0 bus to card |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| mem_rdata | output | 12 | Data the card drives onto the bus, 0 when not driving |

## Verification
The assertions assume the write strobe, field, address and data change only between clock edges and stay stable while a write pulse is active. They also assume reset is held for at least one edge. The bench drives every input one time unit after a rising edge and samples one time unit later. For the asynchronous checks on power-good, direction and address, it samples before the next edge. It holds address and data steady from before each strobe until after the strobe is released.

// File: rtl/ramcard_pkg.sv
package ramcard_pkg;
    typedef enum logic [1:0] {
        WR_OFF   = 2'd0,
        WR_IDLE  = 2'd1,
        WR_PULSE = 2'd2,
        WR_HOLD  = 2'd3
    } wr_state_e;
endpackage

// File: rtl/ramcard_fielddec.sv
module ramcard_fielddec #(
    parameter int FIELD_BITS = 3,
    localparam int NFIELDS = 1 << FIELD_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FIELD_BITS-1:0] fld_sel,
    input  logic                  rom_over_n,
    input  logic [NFIELDS-1:0]    fld_mask,
    output logic                  hit
);
    logic [NFIELDS-1:0] onehot;

    for (genvar g = 0; g < NFIELDS; g++) begin : g_dec
        assign onehot[g] = rom_over_n && (fld_sel == FIELD_BITS'(g));
    end

    assign hit = |(onehot & ~fld_mask);

    // R3
    rom_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_over_n |-> !hit);
    // R2
    mask_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_mask[fld_sel] |-> !hit);
endmodule

// File: rtl/ramcard_wrfsm.sv
module ramcard_wrfsm
    import ramcard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic sel_live,
    input  logic dir_n,
    input  logic wr_stb,
    output logic we_n
);
    wr_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            WR_OFF:   nxt = wr_stb ? WR_HOLD : WR_IDLE;
            WR_IDLE:  if (wr_stb) nxt = (sel_live && dir_n) ? WR_PULSE : WR_HOLD;
            WR_PULSE: nxt = wr_stb ? WR_HOLD : WR_IDLE;
            WR_HOLD:  nxt = wr_stb ? WR_HOLD : WR_IDLE;
        endcase
        if (!pwr_good) nxt = WR_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_OFF;
        else        state <= nxt;
    end

    always_comb begin
        we_n = 1'b1;
        unique case (state)
            WR_PULSE: we_n = !(pwr_good && sel_live);
            WR_OFF, WR_IDLE, WR_HOLD: we_n = 1'b1;
        endcase
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == WR_PULSE |=> state != WR_PULSE);
    // R5
    off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> state == WR_OFF);
endmodule

// File: rtl/ramcard_array.sv
module ramcard_array #(
    parameter int FIELD_BITS = 3,
    parameter int ADDR_BITS  = 12,
    parameter int ROW_BITS   = 6,
    parameter int DATA_BITS  = 12,
    parameter int RAM_BITS   = 16,
    localparam int IDX_BITS  = FIELD_BITS + ROW_BITS,
    localparam int DEPTH     = 1 << IDX_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FIELD_BITS-1:0] fld_sel,
    input  logic [ADDR_BITS-1:0]  word_addr,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  rd_en,
    input  logic [DATA_BITS-1:0]  wdata,
    output logic [DATA_BITS-1:0]  rdata
);
    logic [RAM_BITS-1:0] mem [DEPTH];
    logic [ROW_BITS-1:0] row;
    logic [IDX_BITS-1:0] idx;
    logic [RAM_BITS-1:0] word;

    always_comb begin
        row = '0;
        for (int i = 0; i < ADDR_BITS; i++) row[i % ROW_BITS] ^= word_addr[i];
    end

    assign idx  = {fld_sel, row};
    assign word = mem[idx];
    assign rdata = word[DATA_BITS-1:0];

    always_ff @(posedge clk) begin
        if (!ce_n && !we_n) mem[idx] <= {{(RAM_BITS-DATA_BITS){1'b0}}, wdata};
    end

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> word[RAM_BITS-1:DATA_BITS] == '0);
endmodule

// File: rtl/ramcard_ctrl.sv
module ramcard_ctrl #(
    parameter int FIELD_BITS = 3,
    parameter int ADDR_BITS  = 12,
    parameter int DATA_BITS  = 12,
    parameter int RAM_BITS   = 16,
    parameter int ROW_BITS   = 6,
    localparam int NFIELDS   = 1 << FIELD_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FIELD_BITS-1:0] fld_sel,
    input  logic [ADDR_BITS-1:0]  word_addr,
    input  logic                  rom_over_n,
    input  logic                  dir_n,
    input  logic                  pwr_good,
    input  logic                  wr_stb,
    input  logic [NFIELDS-1:0]    fld_mask,
    input  logic [DATA_BITS-1:0]  mem_wdata,
    output logic                  ram_ce_n,
    output logic                  ram_we_n,
    output logic                  ram_oe_n,
    output logic                  xcvr_dir,
    output logic                  xcvr_en_n,
    output logic [DATA_BITS-1:0]  mem_rdata
);
    logic hit, sel_q, sel_live, drive;
    logic [DATA_BITS-1:0] arr_rdata;

    ramcard_fielddec #(.FIELD_BITS(FIELD_BITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .fld_sel(fld_sel),
        .rom_over_n(rom_over_n), .fld_mask(fld_mask), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= hit && pwr_good;
    end

    assign sel_live = sel_q && pwr_good;
    assign drive    = sel_live && !dir_n;

    ramcard_wrfsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_live(sel_live),
        .dir_n(dir_n), .wr_stb(wr_stb), .we_n(ram_we_n)
    );

    ramcard_array #(
        .FIELD_BITS(FIELD_BITS), .ADDR_BITS(ADDR_BITS), .ROW_BITS(ROW_BITS),
        .DATA_BITS(DATA_BITS), .RAM_BITS(RAM_BITS)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .fld_sel(fld_sel), .word_addr(word_addr),
        .ce_n(ram_ce_n), .we_n(ram_we_n), .rd_en(drive),
        .wdata(mem_wdata), .rdata(arr_rdata)
    );

    assign ram_ce_n  = !sel_live;
    assign ram_oe_n  = !drive;
    assign xcvr_en_n = !sel_live;
    assign xcvr_dir  = drive;
    assign mem_rdata = drive ? arr_rdata : '0;

    // R5
    pwr_fail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> (ram_ce_n && ram_we_n && ram_oe_n));
    // R10
    pwr_return_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> ram_ce_n);
    // R6
    write_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ($past(wr_stb) && dir_n && !ram_ce_n));
    // R4
    drive_needs_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_dir || !ram_oe_n) |-> (!dir_n && !ram_ce_n));
endmodule

// File: tb/ramcard_ctrl_test.sv
module ramcard_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] fld_sel = '0;
    logic [11:0] word_addr = '0;
    logic rom_over_n = 1'b1;
    logic dir_n = 1'b1;
    logic pwr_good = 1'b1;
    logic wr_stb = 1'b0;
    logic [7:0] fld_mask = '0;
    logic [11:0] mem_wdata = '0;
    logic ram_ce_n, ram_we_n, ram_oe_n, xcvr_dir, xcvr_en_n;
    logic [11:0] mem_rdata;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ramcard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fld_sel(fld_sel), .word_addr(word_addr),
        .rom_over_n(rom_over_n), .dir_n(dir_n), .pwr_good(pwr_good),
        .wr_stb(wr_stb), .fld_mask(fld_mask), .mem_wdata(mem_wdata),
        .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .xcvr_dir(xcvr_dir), .xcvr_en_n(xcvr_en_n), .mem_rdata(mem_rdata)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [2:0] f, logic [11:0] a, logic [11:0] d);
        fld_sel = f; word_addr = a; mem_wdata = d; dir_n = 1'b1; wr_stb = 1'b0;
        tick();
        wr_stb = 1'b1;
        tick();
        chk("R6 we_n low after strobe", ram_we_n, 0);
        tick();
        chk("R9 single pulse", ram_we_n, 1);
        wr_stb = 1'b0;
        tick();
    endtask

    task automatic try_write(string tag, logic [2:0] f, logic [11:0] a, logic [11:0] d);
        fld_sel = f; word_addr = a; mem_wdata = d; dir_n = 1'b1;
        tick();
        wr_stb = 1'b1;
        tick();
        chk(tag, ram_we_n, 1);
        tick();
        chk(tag, ram_we_n, 1);
        wr_stb = 1'b0;
        tick();
    endtask

    task automatic read_chk(string tag, logic [2:0] f, logic [11:0] a, logic [11:0] exp);
        fld_sel = f; word_addr = a; dir_n = 1'b0;
        tick();
        chk(tag, mem_rdata, exp);
        dir_n = 1'b1;
    endtask

    function automatic logic [11:0] fill_addr(int f);
        return (f == 7) ? 12'o7777 : 12'(f * 12'o1111);
    endfunction

    function automatic logic [11:0] fill_data(int f);
        return 12'(12'h5A0 ^ (f * 12'h111));
    endfunction

    task automatic t_reset();
        chk("R1 ce_n", ram_ce_n, 1);
        chk("R1 we_n", ram_we_n, 1);
        chk("R1 oe_n", ram_oe_n, 1);
        chk("R1 dir", xcvr_dir, 0);
        chk("R1 rdata", mem_rdata, 0);
    endtask

    task automatic t_fill();
        for (int f = 0; f < 8; f++) do_write(3'(f), fill_addr(f), fill_data(f));
        for (int f = 0; f < 8; f++) read_chk("R6 readback", 3'(f), fill_addr(f), fill_data(f));
        do_write(3'd2, fill_addr(2), 12'hFFF);
        read_chk("R8 all ones 12 bits", 3'd2, fill_addr(2), 12'hFFF);
    endtask

    task automatic t_async();
        // 7777 folds to row 0, 0001 to row 1 in field 7
        do_write(3'd7, 12'o0001, 12'h3C3);
        read_chk("R7 first word", 3'd7, 12'o7777, fill_data(7));
        dir_n = 1'b0;
        #1 word_addr = 12'o0001;
        #1 chk("R7 no clock address change", mem_rdata, 12'h3C3);
        dir_n = 1'b1;
    endtask

    task automatic t_mask();
        fld_mask = 8'h08;
        fld_sel = 3'd3; dir_n = 1'b0;
        tick();
        chk("R2 ce_n masked", ram_ce_n, 1);
        chk("R2 no read drive", mem_rdata, 0);
        chk("R2 dir masked", xcvr_dir, 0);
        try_write("R2 masked write", 3'd3, fill_addr(3), 12'hEEE);
        fld_sel = 3'd4;
        tick();
        chk("R2 other field selected", ram_ce_n, 0);
        fld_mask = 8'h00;
        read_chk("R2 masked field intact", 3'd3, fill_addr(3), fill_data(3));
    endtask

    task automatic t_rom();
        rom_over_n = 1'b0;
        fld_sel = 3'd5; dir_n = 1'b0;
        tick();
        chk("R3 ce_n overlay", ram_ce_n, 1);
        chk("R3 no read drive", mem_rdata, 0);
        try_write("R3 overlay write", 3'd5, fill_addr(5), 12'h111);
        rom_over_n = 1'b1;
        read_chk("R3 field intact", 3'd5, fill_addr(5), fill_data(5));
    endtask

    task automatic t_dir();
        fld_sel = 3'd6; word_addr = fill_addr(6); dir_n = 1'b1;
        tick();
        chk("R4 en while selected", xcvr_en_n, 0);
        chk("R4 dir into ram", xcvr_dir, 0);
        chk("R4 oe off", ram_oe_n, 1);
        chk("R4 rdata zero", mem_rdata, 0);
        dir_n = 1'b0;
        #1;
        chk("R4 dir to bus", xcvr_dir, 1);
        chk("R4 data driven", mem_rdata, fill_data(6));
        dir_n = 1'b1;
    endtask

    task automatic t_power();
        fld_sel = 3'd1; word_addr = fill_addr(1); dir_n = 1'b0;
        tick();
        chk("R5 selected before fail", ram_ce_n, 0);
        pwr_good = 1'b0;
        #1;
        chk("R5 ce_n immediate", ram_ce_n, 1);
        chk("R5 rdata off", mem_rdata, 0);
        try_write("R5 write while power bad", 3'd1, fill_addr(1), 12'h0F0);
        pwr_good = 1'b1;
        #1;
        chk("R10 ce_n waits for edge", ram_ce_n, 1);
        read_chk("R5 data survives", 3'd1, fill_addr(1), fill_data(1));
    endtask

    task automatic t_hold();
        fld_sel = 3'd0; word_addr = fill_addr(0); mem_wdata = 12'h777; dir_n = 1'b1;
        tick();
        wr_stb = 1'b1;
        tick();
        chk("R9 first pulse", ram_we_n, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9 no repeat", ram_we_n, 1);
        end
        wr_stb = 1'b0;
        tick();
        read_chk("R9 value stored", 3'd0, fill_addr(0), 12'h777);
    endtask

    task automatic t_latency();
        fld_sel = 3'd0;
        tick();
        fld_mask = 8'h80;
        fld_sel = 3'd7;
        #1;
        chk("R10 old select held", ram_ce_n, 0);
        tick();
        chk("R10 new select after edge", ram_ce_n, 1);
        fld_mask = 8'h00;
        tick();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_fill();
        t_async();
        t_mask();
        t_rom();
        t_dir();
        t_power();
        t_hold();
        t_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule